// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves one 32-bit virtual address at a time through a two-level short-format page table held in memory. A requester offers a virtual address together with an instruction-fetch flag, a write flag and a context identifier. The walker then reads the first-level descriptor on a one-word read port. Depending on the descriptor type, it either finishes with a section mapping or reads a second-level descriptor and finishes with a large-page or small-page mapping.

Every walk ends with a single-cycle completion pulse. The pulse carries either a translation entry or a fault code. A fault code names the level at which the walk stopped and tells instruction fetches apart from data accesses. The entry carries the translated physical address, the page size exponent, the execute-never and permission bits, the domain and the context identifier. It also carries the raw shareable bit and the 5-bit type/cacheability field, which a separate attribute unit decodes downstream. The table base and the access-flag check enable are captured when a request is accepted.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready_o is 1, and done_o and mem_req_o are 0.
- R2: The first read goes to {ttb_i[31:14], vaddr[31:20], 2'b00}, which is the base with bits 13:0 ignored, OR vaddr[31:20] shifted left by 2.
- R3: A first-level descriptor whose type bits [1:0] are 00 or 11 ends the walk after one read with fault code 1 for a fetch or code 2 for a data access. fault_write_o equals the write flag for code 2 and is 0 for code 1. fault_domain_o is 0.
- R4: A type 10 (section) descriptor with bit 18 clear, and with the access check passing, ends the walk after one read without a fault. Its entry fields are: pa = {d[31:20], vaddr[19:0]}, size 20, xn = d[4], domain = d[8:5], ap = {d[15], d[11:10]}, shr = d[16], texcb = {d[14:12], d[3], d[2]}, asid = the request context.
- R5: A section descriptor with bit 18 set (supersection) ends the walk with fault code 7 and is not translated. This check takes priority over the access check.
- R6: With access checking enabled, a section descriptor whose d[10] is 0 ends the walk with fault code 5 (data-abort form, carrying the write flag).
- R7: A type 01 descriptor causes a second read at {d1[31:10], vaddr[19:12], 2'b00}.
- R8: A second-level descriptor with type bits [1:0] = 00 ends the walk with fault code 3 for a fetch or code 4 for a data access. Code 4 carries the write flag and fault_domain_o = d1[8:5]. Code 3 reports a domain of 0 and a write flag of 0.
- R9: With access checking enabled, a valid second-level descriptor whose d2[4] is 0 ends the walk with fault code 6, carrying the write flag.
- R10: A second-level type 01 (large page) gives pa = {d2[31:16], vaddr[15:0]}, size 16, xn = d2[15], ap = {d2[9], d2[5:4]}, shr = d2[10], texcb = {d2[14:12], d2[3], d2[2]} and domain = d1[8:5].
- R11: A second-level type 1x (small page) gives pa = {d2[31:12], vaddr[11:0]}, size 12, xn = d2[0], ap = {d2[9], d2[5:4]}, shr = d2[10], texcb = {d2[8:6], d2[3], d2[2]} and domain = d1[8:5].
- R12: done_o is high for exactly one cycle per walk. mem_req_o is a one-cycle pulse per read. Requests, base changes and enable changes presented while req_ready_o is 0 have no effect on the walk in progress, and req_ready_o is 1 again in the cycle after done_o.
- R13: With access checking disabled, descriptors with the access bit clear translate normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request, taken only while ready |
| req_ready_o | output | 1 | Walker idle and able to accept |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_fetch_i | input | 1 | 1 for instruction fetch, 0 for data |
| req_write_i | input | 1 | Data access is a write |
| req_ctx_i | input | CTX_W | Context identifier |
| ttb_i | input | 32 | Table base; bits 13:0 ignored |
| afe_i | input | 1 | Enables access-flag checking |
| mem_req_o | output | 1 | One-cycle descriptor read request |
| mem_addr_o | output | 32 | Descriptor read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Descriptor word |
| done_o | output | 1 | Walk finished (one cycle) |
| fault_o | output | 1 | Walk ended in a fault |
| fault_code_o | output | 3 | Fault class: 0 none, 1..7 as in the requirements |
| fault_write_o | output | 1 | Write flag carried by data-form faults |
| fault_domain_o | output | 4 | Domain reported with level-2 data translation faults |
| ent_pa_o | output | 32 | Translated physical address |
| ent_size_o | output | 5 | Page size exponent (20, 16 or 12) |
| ent_xn_o | output | 1 | Execute-never |
| ent_ap_o | output | 3 | Access permission bits |
| ent_domain_o | output | 4 | Domain |
| ent_asid_o | output | CTX_W | Context identifier of the entry |
| ent_shr_o | output | 1 | Raw shareable bit |
| ent_texcb_o | output | 5 | Raw type and cacheability field |

## Verification
The bench aims at the descriptor bits that change the outcome. These are type 11 at the first level, the supersection bit on a section that also fails the access check, and the access bit with checking disabled. A walker that tested these in the wrong order, or that treated type 11 as a section, would return a mapping where a fault is due. Large and small pages place XN and TEX at different positions, so mixing the two field layouts shows up as wrong xn or texcb values. Requests and base changes injected mid-walk would corrupt the read address or the returned entry in a walker that accepted them outside idle. Random read latencies check that responses are taken only in the wait states.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  localparam int unsigned SECTION_N = 20;
  localparam int unsigned LARGE_N   = 16;
  localparam int unsigned SMALL_N   = 12;

  typedef enum logic [2:0] {
    FLT_NONE        = 3'd0,
    FLT_L1_TRANS_PF = 3'd1,
    FLT_L1_TRANS_DA = 3'd2,
    FLT_L2_TRANS_PF = 3'd3,
    FLT_L2_TRANS_DA = 3'd4,
    FLT_L1_ACCESS   = 3'd5,
    FLT_L2_ACCESS   = 3'd6,
    FLT_UNSUPP      = 3'd7
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_st_e;

  typedef enum logic [1:0] {
    K_FAULT, K_LEAF, K_NEXT
  } l1_kind_e;

  typedef struct packed {
    logic [31:0] pa;
    logic [4:0]  size;
    logic        xn;
    logic [2:0]  ap;
    logic [3:0]  domain;
    logic        shr;
    logic [4:0]  texcb;
  } ent_t;

  function automatic logic is_data_form(fault_e f);
    return (f == FLT_L1_TRANS_DA) || (f == FLT_L2_TRANS_DA) ||
           (f == FLT_L1_ACCESS)   || (f == FLT_L2_ACCESS);
  endfunction

endpackage

// File: rtl/pt_l1_decode.sv
module pt_l1_decode
  import pt_walker_pkg::*;
(
  input  logic [31:0] desc_i,
  input  logic [19:0] va_lo_i,
  input  logic        afe_i,
  input  logic        fetch_i,
  output l1_kind_e    kind_o,
  output fault_e      fault_o,
  output ent_t        ent_o,
  output logic [31:0] next_addr_o,
  output logic [3:0]  domain_o
);

  logic unused_bits;
  assign unused_bits = ^{desc_i[17], desc_i[9]};

  assign next_addr_o = {desc_i[31:10], va_lo_i[19:12], 2'b00};
  assign domain_o    = desc_i[8:5];

  always_comb begin
    kind_o  = K_FAULT;
    fault_o = FLT_NONE;
    ent_o   = '0;
    case (desc_i[1:0])
      2'b01: kind_o = K_NEXT;
      2'b10: begin
        // supersection outranks the access check
        if (desc_i[18]) begin
          fault_o = FLT_UNSUPP;
        end else if (afe_i && !desc_i[10]) begin
          fault_o = FLT_L1_ACCESS;
        end else begin
          kind_o       = K_LEAF;
          ent_o.pa     = {desc_i[31:20], va_lo_i};
          ent_o.size   = 5'(SECTION_N);
          ent_o.xn     = desc_i[4];
          ent_o.ap     = {desc_i[15], desc_i[11:10]};
          ent_o.domain = desc_i[8:5];
          ent_o.shr    = desc_i[16];
          ent_o.texcb  = {desc_i[14:12], desc_i[3], desc_i[2]};
        end
      end
      default: fault_o = fetch_i ? FLT_L1_TRANS_PF : FLT_L1_TRANS_DA;
    endcase
  end

endmodule

// File: rtl/pt_l2_decode.sv
module pt_l2_decode
  import pt_walker_pkg::*;
(
  input  logic [31:0] desc_i,
  input  logic [15:0] va_lo_i,
  input  logic        afe_i,
  input  logic        fetch_i,
  input  logic [3:0]  l1_domain_i,
  output logic        leaf_o,
  output fault_e      fault_o,
  output ent_t        ent_o
);

  always_comb begin
    leaf_o  = 1'b0;
    fault_o = FLT_NONE;
    ent_o   = '0;
    if (desc_i[1:0] == 2'b00) begin
      fault_o = fetch_i ? FLT_L2_TRANS_PF : FLT_L2_TRANS_DA;
    end else if (afe_i && !desc_i[4]) begin
      fault_o = FLT_L2_ACCESS;
    end else begin
      leaf_o       = 1'b1;
      ent_o.ap     = {desc_i[9], desc_i[5:4]};
      ent_o.shr    = desc_i[10];
      ent_o.domain = l1_domain_i;
      if (desc_i[1:0] == 2'b01) begin
        ent_o.pa    = {desc_i[31:16], va_lo_i};
        ent_o.size  = 5'(LARGE_N);
        ent_o.xn    = desc_i[15];
        ent_o.texcb = {desc_i[14:12], desc_i[3], desc_i[2]};
      end else begin
        ent_o.pa    = {desc_i[31:12], va_lo_i[11:0]};
        ent_o.size  = 5'(SMALL_N);
        ent_o.xn    = desc_i[0];
        ent_o.texcb = {desc_i[8:6], desc_i[3], desc_i[2]};
      end
    end
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [31:0]      req_vaddr_i,
  input  logic             req_fetch_i,
  input  logic             req_write_i,
  input  logic [CTX_W-1:0] req_ctx_i,
  input  logic [31:0]      ttb_i,
  input  logic             afe_i,
  output logic             mem_req_o,
  output logic [31:0]      mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             done_o,
  output logic             fault_o,
  output logic [2:0]       fault_code_o,
  output logic             fault_write_o,
  output logic [3:0]       fault_domain_o,
  output logic [31:0]      ent_pa_o,
  output logic [4:0]       ent_size_o,
  output logic             ent_xn_o,
  output logic [2:0]       ent_ap_o,
  output logic [3:0]       ent_domain_o,
  output logic [CTX_W-1:0] ent_asid_o,
  output logic             ent_shr_o,
  output logic [4:0]       ent_texcb_o
);

  walk_st_e         state_q;
  logic [31:0]      va_q;
  logic             fetch_q, write_q, afe_q;
  logic [CTX_W-1:0] ctx_q;
  logic [31:0]      l1_addr_q, l2_addr_q;
  logic [3:0]       l1_dom_q;
  ent_t             res_ent_q;
  fault_e           res_fault_q;
  logic             res_wr_q;
  logic [3:0]       res_dom_q;

  logic unused_ttb;
  assign unused_ttb = ^ttb_i[13:0];

  l1_kind_e    l1_kind;
  fault_e      l1_fault;
  ent_t        l1_ent;
  logic [31:0] l1_next;
  logic [3:0]  l1_dom;

  pt_l1_decode u_l1 (
    .desc_i      (mem_rdata_i),
    .va_lo_i     (va_q[19:0]),
    .afe_i       (afe_q),
    .fetch_i     (fetch_q),
    .kind_o      (l1_kind),
    .fault_o     (l1_fault),
    .ent_o       (l1_ent),
    .next_addr_o (l1_next),
    .domain_o    (l1_dom)
  );

  logic   l2_leaf;
  fault_e l2_fault;
  ent_t   l2_ent;

  pt_l2_decode u_l2 (
    .desc_i      (mem_rdata_i),
    .va_lo_i     (va_q[15:0]),
    .afe_i       (afe_q),
    .fetch_i     (fetch_q),
    .l1_domain_i (l1_dom_q),
    .leaf_o      (l2_leaf),
    .fault_o     (l2_fault),
    .ent_o       (l2_ent)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      fetch_q     <= 1'b0;
      write_q     <= 1'b0;
      afe_q       <= 1'b0;
      ctx_q       <= '0;
      l1_addr_q   <= '0;
      l2_addr_q   <= '0;
      l1_dom_q    <= '0;
      res_ent_q   <= '0;
      res_fault_q <= FLT_NONE;
      res_wr_q    <= 1'b0;
      res_dom_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          state_q   <= ST_L1_REQ;
          va_q      <= req_vaddr_i;
          fetch_q   <= req_fetch_i;
          write_q   <= req_write_i;
          afe_q     <= afe_i;
          ctx_q     <= req_ctx_i;
          l1_addr_q <= {ttb_i[31:14], req_vaddr_i[31:20], 2'b00};
        end
        ST_L1_REQ: state_q <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rvalid_i) begin
          l2_addr_q <= l1_next;
          l1_dom_q  <= l1_dom;
          res_dom_q <= '0;
          if (l1_kind == K_NEXT) begin
            state_q <= ST_L2_REQ;
          end else begin
            state_q     <= ST_DONE;
            res_ent_q   <= (l1_kind == K_LEAF) ? l1_ent : '0;
            res_fault_q <= l1_fault;
            res_wr_q    <= write_q && is_data_form(l1_fault);
          end
        end
        ST_L2_REQ: state_q <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rvalid_i) begin
          state_q     <= ST_DONE;
          res_ent_q   <= l2_leaf ? l2_ent : '0;
          res_fault_q <= l2_fault;
          res_wr_q    <= write_q && is_data_form(l2_fault);
          res_dom_q   <= (l2_fault == FLT_L2_TRANS_DA) ? l1_dom_q : '0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o    = (state_q == ST_IDLE);
  assign mem_req_o      = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign mem_addr_o     = (state_q == ST_L2_REQ) ? l2_addr_q : l1_addr_q;
  assign done_o         = (state_q == ST_DONE);
  assign fault_o        = (res_fault_q != FLT_NONE);
  assign fault_code_o   = res_fault_q;
  assign fault_write_o  = res_wr_q;
  assign fault_domain_o = res_dom_q;
  assign ent_pa_o       = res_ent_q.pa;
  assign ent_size_o     = res_ent_q.size;
  assign ent_xn_o       = res_ent_q.xn;
  assign ent_ap_o       = res_ent_q.ap;
  assign ent_domain_o   = res_ent_q.domain;
  assign ent_shr_o      = res_ent_q.shr;
  assign ent_texcb_o    = res_ent_q.texcb;
  assign ent_asid_o     = ctx_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12
  AST_MEM_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R12
  AST_PA_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o |-> ent_pa_o[11:0] == va_q[11:0]); // R4
  AST_SIZE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o |-> (ent_size_o == 5'd20 || ent_size_o == 5'd16 || ent_size_o == 5'd12)); // R11
  AST_PF_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (fault_code_o == 3'd1 || fault_code_o == 3'd3) |-> !fault_write_o); // R3
  AST_FAULT_NO_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> ent_size_o == 5'd0); // R8

endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_fetch = 1'b0, req_write = 1'b0;
  logic [7:0]  req_ctx = '0;
  logic [31:0] ttb = 32'h0004_0000;
  logic        afe = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, flt, fwr, xn, shr;
  logic [2:0]  fcode, ap;
  logic [3:0]  fdom, dom;
  logic [31:0] pa;
  logic [4:0]  sz, texcb;
  logic [7:0]  asid;

  int n_chk = 0, n_fail = 0, n_cyc = 0;
  int nrd = 0;
  logic [31:0] rd_addr [2];
  logic [31:0] cur_d1, cur_d2;

  always #4 clk = ~clk;

  pt_walker #(.CTX_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .req_fetch_i(req_fetch), .req_write_i(req_write), .req_ctx_i(req_ctx),
    .ttb_i(ttb), .afe_i(afe),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .fault_o(flt), .fault_code_o(fcode), .fault_write_o(fwr), .fault_domain_o(fdom),
    .ent_pa_o(pa), .ent_size_o(sz), .ent_xn_o(xn), .ent_ap_o(ap), .ent_domain_o(dom),
    .ent_asid_o(asid), .ent_shr_o(shr), .ent_texcb_o(texcb)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      n_cyc++;
      if (n_cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", n_cyc);
        finish_run();
      end
    end
  end

  // behavioural descriptor memory: one word per read in walk order
  initial begin
    logic [31:0] d;
    int lat;
    #1;
    forever begin
      if (mem_req === 1'b1) begin
        if (nrd < 2) rd_addr[nrd] = mem_addr;
        d = (nrd == 0) ? cur_d1 : cur_d2;
        nrd++;
        lat = $urandom % 4;
        @(posedge clk);
        repeat (lat) @(posedge clk);
        #1 mem_rvalid = 1'b1; mem_rdata = d;
        @(posedge clk);
        #1 mem_rvalid = 1'b0; mem_rdata = $urandom;
      end else begin
        @(posedge clk); #1;
      end
    end
  end

  function automatic logic is_data(logic [2:0] c);
    return c == 3'd2 || c == 3'd4 || c == 3'd5 || c == 3'd6;
  endfunction

  task automatic walk(input logic [31:0] va, input logic fe, input logic wr, input logic [7:0] ctx,
                      input logic af, input logic [31:0] d1, input logic [31:0] d2,
                      input bit poke, input string tag_ovr);
    logic [2:0]  e_code = 3'd0;
    logic [3:0]  e_fdom = '0, e_dom = '0;
    logic [31:0] e_pa = '0, a1, a2 = '0;
    logic [4:0]  e_sz = '0, e_tex = '0;
    logic [2:0]  e_ap = '0;
    logic        e_xn = 0, e_shr = 0;
    int          e_nrd = 1;
    string       tag;
    int          w = 0;
    a1 = {ttb[31:14], va[31:20], 2'b00};
    if (d1[1:0] == 2'b01) begin
      e_nrd = 2;
      a2 = {d1[31:10], va[19:12], 2'b00};
      if (d2[1:0] == 2'b00) begin
        e_code = fe ? 3'd3 : 3'd4; e_fdom = fe ? 4'd0 : d1[8:5]; tag = "R8";
      end else if (af && !d2[4]) begin
        e_code = 3'd6; tag = "R9";
      end else begin
        e_dom = d1[8:5]; e_ap = {d2[9], d2[5:4]}; e_shr = d2[10];
        if (d2[1:0] == 2'b01) begin
          e_pa = {d2[31:16], va[15:0]}; e_sz = 16; e_xn = d2[15];
          e_tex = {d2[14:12], d2[3:2]}; tag = "R10";
        end else begin
          e_pa = {d2[31:12], va[11:0]}; e_sz = 12; e_xn = d2[0];
          e_tex = {d2[8:6], d2[3:2]}; tag = "R11";
        end
      end
    end else if (d1[1:0] == 2'b10) begin
      if (d1[18]) begin e_code = 3'd7; tag = "R5"; end
      else if (af && !d1[10]) begin e_code = 3'd5; tag = "R6"; end
      else begin
        e_pa = {d1[31:20], va[19:0]}; e_sz = 20; e_xn = d1[4]; e_dom = d1[8:5];
        e_ap = {d1[15], d1[11:10]}; e_shr = d1[16]; e_tex = {d1[14:12], d1[3:2]}; tag = "R4";
      end
    end else begin
      e_code = fe ? 3'd1 : 3'd2; tag = "R3";
    end
    if (tag_ovr != "") tag = tag_ovr;

    cur_d1 = d1; cur_d2 = d2; nrd = 0;
    while (req_ready !== 1'b1) begin @(posedge clk); #1; end
    req_valid = 1; req_vaddr = va; req_fetch = fe; req_write = wr; req_ctx = ctx; afe = af;
    @(posedge clk); #1;
    req_valid = 0;
    if (poke) begin
      // busy-time request and base/enable changes must not disturb the walk (R12)
      req_valid = 1; req_vaddr = ~va; req_fetch = ~fe; req_write = ~wr; req_ctx = ~ctx;
      afe = ~af; ttb = ~ttb;
      @(posedge clk); #1;
      req_valid = 0; ttb = ~ttb; afe = af;
    end
    while (done !== 1'b1 && w < 60) begin @(posedge clk); #1; w++; end
    chk(tag, "done seen", {31'd0, done}, 32'd1);
    if (done !== 1'b1) return;
    chk(tag, "fault code", {29'd0, fcode}, {29'd0, e_code});
    chk(tag, "fault flag", {31'd0, flt}, {31'd0, e_code != 0});
    chk(tag, "fault write", {31'd0, fwr}, {31'd0, wr && is_data(e_code)});
    chk(tag, "fault domain", {28'd0, fdom}, {28'd0, e_fdom});
    chk(tag, "read count", nrd, e_nrd);
    chk("R2", "L1 address", rd_addr[0], a1);
    if (e_nrd == 2 && nrd >= 2) chk("R7", "L2 address", rd_addr[1], a2);
    if (e_code == 0) begin
      chk(tag, "pa", pa, e_pa);
      chk(tag, "size", {27'd0, sz}, {27'd0, e_sz});
      chk(tag, "xn", {31'd0, xn}, {31'd0, e_xn});
      chk(tag, "ap", {29'd0, ap}, {29'd0, e_ap});
      chk(tag, "domain", {28'd0, dom}, {28'd0, e_dom});
      chk(tag, "shr", {31'd0, shr}, {31'd0, e_shr});
      chk(tag, "texcb", {27'd0, texcb}, {27'd0, e_tex});
      chk(tag, "asid", {24'd0, asid}, {24'd0, ctx});
    end
    @(posedge clk); #1;
    chk("R12", "done one cycle", {31'd0, done}, 32'd0);
    chk("R12", "ready after done", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    void'($urandom(32'd7301));
    #3;
    chk("R1", "ready in reset", {31'd0, req_ready}, 32'd1);
    chk("R1", "done in reset", {31'd0, done}, 32'd0);
    chk("R1", "mem_req in reset", {31'd0, mem_req}, 32'd0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    chk("R1", "ready after reset", {31'd0, req_ready}, 32'd1);

    walk(32'h1234_5678, 1, 0, 8'h11, 1, 32'h0000_0000, 0, 0, "R3");
    walk(32'h8765_4321, 0, 1, 8'h22, 0, 32'hFFFF_FFF3, 0, 0, "R3");
    walk(32'hABCD_E012, 0, 1, 8'h33, 1, 32'h4561_C41E, 0, 0, "R4");
    walk(32'h0010_0FFF, 0, 0, 8'h44, 0, 32'h7004_0402, 0, 0, "R5");
    walk(32'h00F0_0000, 0, 1, 8'h55, 1, 32'h9000_0BE2, 0, 0, "R6");
    walk(32'h3FFF_F000, 0, 0, 8'h66, 0, 32'h9000_01E2, 0, 0, "R13");
    walk(32'hC03A_5ABC, 0, 1, 8'h77, 1, 32'h00AB_C1A1, 32'hDEAD_B5DE, 0, "R11");
    walk(32'h5555_AAAA, 1, 0, 8'h88, 1, 32'h00AB_C1A1, 32'hBEEF_FA35, 0, "R10");
    walk(32'h0FF0_0FF0, 1, 0, 8'h99, 1, 32'h1234_5561, 32'hFFFF_FFFC, 0, "R8");
    walk(32'h0FF0_0FF0, 0, 1, 8'hAA, 1, 32'h1234_55E1, 32'hFFFF_FFFC, 0, "R8");
    walk(32'h7777_1234, 0, 1, 8'hBB, 1, 32'h0000_0021, 32'h1234_56E2, 0, "R9");
    walk(32'h7777_1234, 0, 0, 8'hCC, 0, 32'h0000_0021, 32'h1234_56E1, 0, "R13");
    walk(32'h2468_ACE0, 0, 1, 8'hDD, 1, 32'hFEDC_B1E1, 32'h1357_9BD3, 1, "R12");
    walk(32'h9ABC_0000, 1, 0, 8'hEE, 0, 32'h9AB0_5DE2, 0, 1, "R12");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] d1 = $urandom;
      logic [31:0] d2 = $urandom;
      logic [31:0] va = $urandom;
      ttb = $urandom;
      walk(va, 1'($urandom), 1'($urandom), 8'($urandom), 1'($urandom), d1, d2,
           ($urandom % 4) == 0, "");
    end
    finish_run();
  end

endmodule